// File: doc/BRIEF.md
# Hardware Cursor Pixel Overlay

This stage sits in a streamed display pixel path and draws a 32x32 hardware cursor over the picture. It accepts one display pixel per cycle, tagged with its screen column and row. When that position falls inside the cursor window, the stage fetches the matching cursor texel from a local memory. It then emits either the original pixel, the cursor colour in its place, or the cursor colour XORed into the pixel.

Cursor texels are 16 bits wide. Bit 15 selects the mode (1 = replace, 0 = XOR). Bits 14:10 hold red, bits 9:5 green and bits 4:0 blue. Software loads the cursor memory through a write port before or between frames. It sets the window's top-left corner, a disable bit and the framebuffer pixel format. The output follows its input by exactly two clock cycles.

Top module: `hw_cursor_overlay`

## Requirements
- R1: A pixel at (x, y) is inside the window when cur_x <= x < cur_x+32 and cur_y <= y < cur_y+32. A pixel outside the window leaves with its value unchanged.
- R2: Inside the window the texel is read from word address (y-cur_y)*32 + (x-cur_x), so the cursor is stored row by row. That address is also the write port's address.
- R3: A texel of 0x0000 is transparent, and the display pixel passes through unchanged.
- R4: A non-zero texel with bit 15 set replaces the display pixel's colour bits with the cursor colour.
- R5: A non-zero texel with bit 15 clear is XORed into the display pixel, with bit 15 taken as zero.
- R6: In 8-bit format (fmt = 0) only pixel bits 7:0 are affected, using texel bits 7:0. Bits 31:8 pass through.
- R7: In 16-bit format (fmt = 1) pixel bits 15:0 are affected, using the 16-bit colour value. Bits 31:16 pass through.
- R8: In 32-bit format (fmt = 2 or 3) the colour is expanded to {8'h00, R8, G8, B8}. Each 8-bit channel is its 5-bit field followed by that field's top three bits. The expanded value replaces all 32 pixel bits or is XORed into them.
- R9: While cur_off is 1, every pixel passes through unchanged.
- R10: out_valid and out_pix reflect the pixel presented two cycles earlier. Position, disable and format are sampled together with that pixel. Reset clears out_valid and out_pix to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cur_we | input | 1 | Cursor memory write strobe |
| cur_waddr | input | 10 | Cursor memory word address (row*32 + column) |
| cur_wdata | input | 16 | Cursor texel to write |
| cur_x | input | COORD_W | Window left column |
| cur_y | input | COORD_W | Window top row |
| cur_off | input | 1 | 1 disables the cursor |
| fmt | input | 2 | Framebuffer format: 0 = 8-bit, 1 = 16-bit, 2/3 = 32-bit |
| in_valid | input | 1 | Input pixel valid |
| in_x | input | COORD_W | Input pixel column |
| in_y | input | COORD_W | Input pixel row |
| in_pix | input | 32 | Input display pixel |
| out_valid | output | 1 | Output pixel valid |
| out_pix | output | 32 | Output pixel |

## Verification
The bench builds the block with its default parameters: a 32x32 cursor and 12-bit coordinates. It fills all 1024 texels with a computed pattern that mixes transparent, replace and XOR texels. It then sweeps a square two pixels larger than the window on every side, so every texel and every window edge is hit. The sweep runs in each format code, with the window at screen origin, with the cursor disabled, and with periodic bubbles in the input stream.

// File: rtl/hw_cursor_overlay.sv
module hw_cursor_overlay #(
  parameter int COORD_W   = 12,
  parameter int SIZE_LOG2 = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cur_we,
  input  logic [2*SIZE_LOG2-1:0] cur_waddr,
  input  logic [15:0]        cur_wdata,
  input  logic [COORD_W-1:0] cur_x,
  input  logic [COORD_W-1:0] cur_y,
  input  logic               cur_off,
  input  logic [1:0]         fmt,
  input  logic               in_valid,
  input  logic [COORD_W-1:0] in_x,
  input  logic [COORD_W-1:0] in_y,
  input  logic [31:0]        in_pix,
  output logic               out_valid,
  output logic [31:0]        out_pix
);
  localparam int SIZE  = 1 << SIZE_LOG2;
  localparam int AW    = 2 * SIZE_LOG2;
  localparam int DEPTH = 1 << AW;

  logic [15:0] mem [DEPTH];
  logic [15:0] tex;
  logic [COORD_W-1:0] dx, dy;
  logic in_win;
  logic [AW-1:0] rd_addr;

  assign dx      = in_x - cur_x;
  assign dy      = in_y - cur_y;
  assign in_win  = (in_x >= cur_x) && (in_y >= cur_y) &&
                   (dx < COORD_W'(SIZE)) && (dy < COORD_W'(SIZE));
  assign rd_addr = {dy[SIZE_LOG2-1:0], dx[SIZE_LOG2-1:0]};

  always_ff @(posedge clk) begin
    if (cur_we) mem[cur_waddr] <= cur_wdata;
    tex <= mem[rd_addr];
  end

  logic        s1_valid, s1_hit;
  logic [31:0] s1_pix;
  logic [1:0]  s1_fmt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_hit   <= 1'b0;
      s1_pix   <= '0;
      s1_fmt   <= '0;
    end else begin
      s1_valid <= in_valid;
      s1_hit   <= in_win && !cur_off;
      s1_pix   <= in_pix;
      s1_fmt   <= fmt;
    end
  end

  wire        repl  = tex[15];
  wire [15:0] col16 = repl ? tex : {1'b0, tex[14:0]};
  wire [31:0] col32 = {8'h00, tex[14:10], tex[14:12], tex[9:5], tex[9:7],
                       tex[4:0], tex[4:2]};
  logic [31:0] mixed;

  always_comb begin
    mixed = s1_pix;
    if (s1_hit && tex != 16'h0000) begin
      if (s1_fmt == 2'd0)
        mixed[7:0]  = repl ? col16[7:0] : s1_pix[7:0] ^ col16[7:0];
      else if (s1_fmt == 2'd1)
        mixed[15:0] = repl ? col16 : s1_pix[15:0] ^ col16;
      else
        mixed       = repl ? col32 : s1_pix ^ col32;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_pix   <= '0;
    end else begin
      out_valid <= s1_valid;
      out_pix   <= mixed;
    end
  end

  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  assert_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2) |-> (out_valid == $past(in_valid, 2)));

  assert_disabled_pass_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2 && $past(cur_off, 2)) |-> (out_pix == $past(in_pix, 2)));

  assert_outside_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2 && !$past(in_win, 2)) |-> (out_pix == $past(in_pix, 2)));

  assert_transparent_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2 && $past(tex) == 16'h0000) |-> (out_pix == $past(s1_pix)));

  assert_replace16_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2 && $past(s1_hit) && $past(s1_fmt) == 2'd1 && $past(tex[15]))
      |-> (out_pix[15:0] == $past(tex)));
endmodule

// File: tb/hw_cursor_overlay_tb.sv
module hw_cursor_overlay_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 12;
  localparam int SZ = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cur_we = 1'b0;
  logic [9:0] cur_waddr = '0;
  logic [15:0] cur_wdata = '0;
  logic [CW-1:0] cur_x = '0, cur_y = '0, in_x = '0, in_y = '0;
  logic cur_off = 1'b0, in_valid = 1'b0;
  logic [1:0] fmt = '0;
  logic [31:0] in_pix = '0;
  logic out_valid;
  logic [31:0] out_pix;

  int checks = 0, fails = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  hw_cursor_overlay #(.COORD_W(CW), .SIZE_LOG2(5)) u_dut (
    .clk(clk), .rst_n(rst_n), .cur_we(cur_we), .cur_waddr(cur_waddr),
    .cur_wdata(cur_wdata), .cur_x(cur_x), .cur_y(cur_y), .cur_off(cur_off),
    .fmt(fmt), .in_valid(in_valid), .in_x(in_x), .in_y(in_y), .in_pix(in_pix),
    .out_valid(out_valid), .out_pix(out_pix));

  function automatic logic [15:0] texel(int a);
    logic [15:0] t;
    t = 16'(a * 40503) ^ 16'(a << 7) ^ 16'(a >> 3);
    if (a % 5 == 0) t = 16'h0000;
    return t;
  endfunction

  function automatic logic [31:0] disp(int x, int y);
    return 32'(x * 32'h9E3779B1) ^ 32'(y * 32'h85EBCA6B);
  endfunction

  function automatic logic [31:0] model(int x, int y, int cx, int cy, bit off,
                                        logic [1:0] f, logic [31:0] p);
    logic [15:0] t, c;
    logic [31:0] e;
    if (x < cx || x >= cx + SZ || y < cy || y >= cy + SZ || off) return p;
    t = texel((y - cy) * SZ + (x - cx));   // R2: row-major addressing
    if (t == 16'h0000) return p;
    c = t[15] ? t : (t & 16'h7FFF);
    if (f == 2'd0) return t[15] ? {p[31:8], c[7:0]} : p ^ {24'h0, c[7:0]};
    if (f == 2'd1) return t[15] ? {p[31:16], c} : p ^ {16'h0, c};
    e = {8'h00, t[14:10], t[14:12], t[9:5], t[9:7], t[4:0], t[4:2]};
    return t[15] ? e : p ^ e;
  endfunction

  function automatic string tag_of(int x, int y, int cx, int cy, bit off, logic [1:0] f);
    logic [15:0] t;
    string m, s;
    if (x < cx || x >= cx + SZ || y < cy || y >= cy + SZ) return "R1";
    if (off) return "R9";
    t = texel((y - cy) * SZ + (x - cx));
    if (t == 16'h0000) return "R3";
    m = t[15] ? "R4" : "R5";
    s = (f == 2'd0) ? "R6" : (f == 2'd1) ? "R7" : "R8";
    return {m, "/", s, "/R2"};
  endfunction

  task automatic step(bit v, int x, int y);
    @(negedge clk);
    if (out_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R10 unexpected out_valid: actual 1 expected 0");
      end else begin
        logic [31:0] e;
        string tg;
        e = exp_q.pop_front();
        tg = tag_q.pop_front();
        if (out_pix !== e) begin
          fails++;
          $display("FAIL %s out_pix actual %h expected %h", tg, out_pix, e);
        end
      end
    end
    in_valid = v;
    in_x = CW'(x);
    in_y = CW'(y);
    in_pix = disp(x, y);
    if (v) begin
      exp_q.push_back(model(x, y, int'(cur_x), int'(cur_y), cur_off, fmt, in_pix));
      tag_q.push_back(tag_of(x, y, int'(cur_x), int'(cur_y), cur_off, fmt));
    end
  endtask

  task automatic sweep(int cx, int cy, bit off, logic [1:0] f);
    int n = 0;
    for (int i = 0; i < 3; i++) step(1'b0, 0, 0);
    cur_x = CW'(cx); cur_y = CW'(cy); cur_off = off; fmt = f;
    for (int y = cy - 2; y < cy + SZ + 2; y++)
      for (int x = cx - 2; x < cx + SZ + 2; x++)
        if (x >= 0 && y >= 0) begin
          n++;
          if (n % 7 == 0) step(1'b0, 0, 0);
          step(1'b1, x, y);
        end
    for (int i = 0; i < 3; i++) step(1'b0, 0, 0);
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R10 missing outputs: actual %0d left expected 0", exp_q.size());
      exp_q.delete(); tag_q.delete();
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    checks++;
    $display("FAIL watchdog expired: actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 3);
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_pix !== 32'h0) begin
      fails++;
      $display("FAIL R10 reset state: actual %b/%h expected 0/00000000", out_valid, out_pix);
    end
    rst_n = 1'b1;
    for (int a = 0; a < SZ * SZ; a++) begin
      @(negedge clk);
      cur_we = 1'b1; cur_waddr = 10'(a); cur_wdata = texel(a);
    end
    @(negedge clk);
    cur_we = 1'b0;
    sweep(100, 50, 1'b0, 2'd0);
    sweep(100, 50, 1'b0, 2'd1);
    sweep(7, 3, 1'b0, 2'd2);
    sweep(0, 0, 1'b0, 2'd3);
    sweep(100, 50, 1'b1, 2'd2);
    sweep(300, 200, 1'b0, 2'd1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule